// File: doc/BRIEF.md
# Lane Fetch Command Sequencer

This unit sits at the front of one execution lane. It takes two kinds of fetch command and turns each into a stream of execute directives. Each directive is a pair: the slot of a small instruction-block cache and the virtual-processor number the block runs for. A broadcast fetch names only a block address. The block then runs once for every virtual processor that lives on this lane. Processors are dealt to lanes round-robin, so a lane holds `LANE_ID`, `LANE_ID+NUM_LANES`, `LANE_ID+2*NUM_LANES` and so on. A thread fetch names a block address and the one processor that asked for it, and it yields exactly one directive.

Every command gets one tag check against a four-slot tag array, and that check covers all the directives the command produces. On a miss the unit requests a fill of the next slot in round-robin order. It waits until the fill completes, then installs the tag and issues. Thread requests wait in a small FIFO and are served first. A broadcast is taken only when no thread work is queued or running, so that threads finish before the next controller command begins.

Top module: `lane_fetch_seq`

## Requirements
- R1: After reset, `dir_valid`, `fill_req` and `bc_done` are low, while `bc_ready` and `tf_ready` are high. Every tag is invalid, so the first fetch of any address misses.
- R2: A broadcast fetch produces `NUM_VP/NUM_LANES` directives on consecutive cycles. Their `dir_vp` values are `LANE_ID + k*NUM_LANES` for k = 0, 1, … in ascending order. On a hit, the first directive appears two cycles after the cycle in which the command is accepted.
- R3: A thread fetch produces exactly one directive, and its `dir_vp` equals the `tf_vp` that came with the request.
- R4: `bc_done` is high for exactly one cycle: the cycle right after the last directive of a broadcast. A thread fetch never raises it.
- R5: On a miss, `fill_req` stays high, with `fill_addr` equal to the block address and `fill_slot` equal to the victim slot, until a cycle in which `fill_done` is high. No directive is issued while the fill is outstanding. The directives that follow carry the filled slot in `dir_slot`, starting in the cycle after `fill_done`.
- R6: On a hit, no fill is requested and `dir_slot` is the slot that holds the matching tag.
- R7: Successive fills use slots 0, 1, 2, 3, 0, … in that order.
- R8: Thread requests are queued up to 4 deep and are served in arrival order. `tf_ready` is low exactly when the queue is full, and a request offered while it is low is not taken.
- R9: A broadcast is accepted only when `bc_ready` is high, which means the unit is idle and the thread queue is empty. A `bc_valid` pulse while `bc_ready` is low is ignored and yields no directives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bc_valid | input | 1 | Broadcast fetch offered |
| bc_addr | input | ADDR_W | Block address of the broadcast fetch |
| bc_ready | output | 1 | Broadcast fetch can be accepted this cycle |
| tf_valid | input | 1 | Thread fetch offered |
| tf_addr | input | ADDR_W | Block address of the thread fetch |
| tf_vp | input | VP_W | Requesting virtual processor |
| tf_ready | output | 1 | Thread queue has room |
| fill_req | output | 1 | Fill of a missed block requested (held) |
| fill_addr | output | ADDR_W | Address to fill |
| fill_slot | output | SLOT_W | Cache slot being filled |
| fill_done | input | 1 | Fill has completed |
| dir_valid | output | 1 | Execute directive valid |
| dir_slot | output | SLOT_W | Cache slot to execute |
| dir_vp | output | VP_W | Virtual processor to execute for |
| bc_done | output | 1 | One-cycle pulse after the last broadcast directive |

## Verification
The bench targets four corner cases:
- A fifth distinct address must wrap the victim pointer to slot 0. A design with a broken round-robin pointer would overwrite a live tag or fail to reuse slot 0.
- A thread request can hit a tag that was just filled by an earlier queued thread. A design that lost its installed tags would request a second fill.
- The thread queue is driven until it is full, so `tf_ready` falls. An overflowing queue would drop or repeat a request.
- A stray `bc_valid` pulse arrives while threads are pending. A design that took it would issue an unexpected broadcast of four directives, and the check on `bc_done` would also catch it.

Every cycle is also compared against a reference model, which catches off-by-one timing of the done pulse and the cycle after a fill.

// File: rtl/lane_fetch_seq.sv
module lane_fetch_seq #(
  parameter int NUM_LANES = 4,
  parameter int LANE_ID   = 0,
  parameter int NUM_VP    = 16,
  parameter int ADDR_W    = 16,
  parameter int SLOTS     = 4,
  parameter int TQ_DEPTH  = 4,
  localparam int VP_W     = $clog2(NUM_VP),
  localparam int SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bc_valid,
  input  logic [ADDR_W-1:0] bc_addr,
  output logic              bc_ready,
  input  logic              tf_valid,
  input  logic [ADDR_W-1:0] tf_addr,
  input  logic [VP_W-1:0]   tf_vp,
  output logic              tf_ready,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [SLOT_W-1:0] fill_slot,
  input  logic              fill_done,
  output logic              dir_valid,
  output logic [SLOT_W-1:0] dir_slot,
  output logic [VP_W-1:0]   dir_vp,
  output logic              bc_done
);
  localparam int VPL  = NUM_VP / NUM_LANES;
  localparam int IDX_W = (VPL > 1) ? $clog2(VPL) : 1;
  localparam int QP_W = (TQ_DEPTH > 1) ? $clog2(TQ_DEPTH) : 1;
  localparam int QC_W = $clog2(TQ_DEPTH + 1);
  localparam logic [VP_W-1:0] LANE_V = VP_W'(LANE_ID);
  localparam logic [VP_W-1:0] STRIDE = VP_W'(NUM_LANES);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_FILL, S_ISSUE} state_t;

  state_t            state;
  logic [ADDR_W-1:0] cur_addr;
  logic [VP_W-1:0]   cur_vp;
  logic              cur_thread;
  logic [SLOT_W-1:0] cur_slot;
  logic [IDX_W-1:0]  idx;
  logic              done_q;
  logic [SLOT_W-1:0] victim;

  logic [ADDR_W-1:0] tag  [SLOTS];
  logic [SLOTS-1:0]  tvld;

  logic [ADDR_W-1:0] q_addr [TQ_DEPTH];
  logic [VP_W-1:0]   q_vp   [TQ_DEPTH];
  logic [QP_W-1:0]   q_rd, q_wr;
  logic [QC_W-1:0]   q_cnt;

  logic q_empty, q_full, push, pop, take_bc, last;
  logic hit;
  logic [SLOT_W-1:0] hit_slot;

  assign q_empty = (q_cnt == '0);
  assign q_full  = (q_cnt == QC_W'(TQ_DEPTH));
  assign push    = tf_valid && !q_full;
  assign pop     = (state == S_IDLE) && !q_empty;
  assign take_bc = (state == S_IDLE) && q_empty && bc_valid;
  assign last    = cur_thread || (idx == IDX_W'(VPL - 1));

  always_comb begin
    hit      = 1'b0;
    hit_slot = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (tvld[i] && tag[i] == cur_addr) begin
        hit      = 1'b1;
        hit_slot = SLOT_W'(i);
      end
    end
  end

  function automatic logic [QP_W-1:0] q_next(input logic [QP_W-1:0] p);
    return (p == QP_W'(TQ_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rd  <= '0;
      q_wr  <= '0;
      q_cnt <= '0;
    end else begin
      if (push) begin
        q_addr[q_wr] <= tf_addr;
        q_vp[q_wr]   <= tf_vp;
        q_wr         <= q_next(q_wr);
      end
      if (pop) q_rd <= q_next(q_rd);
      if (push && !pop) q_cnt <= q_cnt + 1'b1;
      else if (pop && !push) q_cnt <= q_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tvld   <= '0;
      victim <= '0;
      for (int i = 0; i < SLOTS; i++) tag[i] <= '0;
    end else if (state == S_FILL && fill_done) begin
      tag[victim]  <= cur_addr;
      tvld[victim] <= 1'b1;
      victim       <= (victim == SLOT_W'(SLOTS - 1)) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_addr   <= '0;
      cur_vp     <= '0;
      cur_thread <= 1'b0;
      cur_slot   <= '0;
      idx        <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= (state == S_ISSUE) && !cur_thread && last;
      case (state)
        S_IDLE: begin
          if (pop) begin
            cur_addr   <= q_addr[q_rd];
            cur_vp     <= q_vp[q_rd];
            cur_thread <= 1'b1;
            state      <= S_CHECK;
          end else if (take_bc) begin
            cur_addr   <= bc_addr;
            cur_thread <= 1'b0;
            state      <= S_CHECK;
          end
        end
        S_CHECK: begin
          idx <= '0;
          if (hit) begin
            cur_slot <= hit_slot;
            state    <= S_ISSUE;
          end else begin
            state <= S_FILL;
          end
        end
        S_FILL: begin
          if (fill_done) begin
            cur_slot <= victim;
            state    <= S_ISSUE;
          end
        end
        default: begin
          if (last) state <= S_IDLE;
          else idx <= idx + 1'b1;
        end
      endcase
    end
  end

  assign bc_ready  = (state == S_IDLE) && q_empty;
  assign tf_ready  = !q_full;
  assign fill_req  = (state == S_FILL);
  assign fill_addr = cur_addr;
  assign fill_slot = victim;
  assign dir_valid = (state == S_ISSUE);
  assign dir_slot  = cur_slot;
  assign dir_vp    = cur_thread ? cur_vp : LANE_V + VP_W'(idx) * STRIDE;
  assign bc_done   = done_q;
endmodule

// File: rtl/lane_fetch_seq_chk.sv
module lane_fetch_seq_chk #(
  parameter int NUM_LANES = 4,
  parameter int LANE_ID   = 0,
  parameter int VP_W      = 4,
  parameter int ADDR_W    = 16,
  parameter int SLOT_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bc_ready,
  input logic              fill_req,
  input logic [ADDR_W-1:0] fill_addr,
  input logic [SLOT_W-1:0] fill_slot,
  input logic              fill_done,
  input logic              dir_valid,
  input logic [SLOT_W-1:0] dir_slot,
  input logic [VP_W-1:0]   dir_vp,
  input logic              bc_done
);
  AST_DIR_ON_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_valid |-> (int'(dir_vp) % NUM_LANES) == LANE_ID); // R2
  AST_DIR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_valid && $past(dir_valid) |-> dir_vp == $past(dir_vp) + VP_W'(NUM_LANES)); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    bc_done |-> $past(dir_valid) && !dir_valid); // R4
  AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_done |=> fill_req && $stable(fill_addr) && $stable(fill_slot)); // R5
  AST_FILL_NO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !dir_valid); // R5
  AST_FILL_SLOT_USED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_req && fill_done) |-> dir_valid && dir_slot == $past(fill_slot)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bc_ready |-> !dir_valid && !fill_req); // R9
endmodule

bind lane_fetch_seq lane_fetch_seq_chk #(
  .NUM_LANES(NUM_LANES), .LANE_ID(LANE_ID), .VP_W(VP_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
) u_chk (.*);

// File: tb/lane_fetch_seq_bench.sv
`timescale 1ns/1ps
module lane_fetch_seq_bench;
  localparam int NL = 4, LID = 0, NVP = 16, AW = 16;
  localparam int VPL = NVP / NL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bc_valid = 1'b0, tf_valid = 1'b0, fill_done = 1'b0;
  logic [AW-1:0] bc_addr = '0, tf_addr = '0;
  logic [3:0] tf_vp = '0;
  logic bc_ready, tf_ready, fill_req, dir_valid, bc_done;
  logic [AW-1:0] fill_addr;
  logic [1:0] fill_slot, dir_slot;
  logic [3:0] dir_vp;

  lane_fetch_seq #(.NUM_LANES(NL), .LANE_ID(LID), .NUM_VP(NVP), .ADDR_W(AW)) u_lane_fetch_seq (
    .clk(clk), .rst_n(rst_n), .bc_valid(bc_valid), .bc_addr(bc_addr), .bc_ready(bc_ready),
    .tf_valid(tf_valid), .tf_addr(tf_addr), .tf_vp(tf_vp), .tf_ready(tf_ready),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_slot(fill_slot), .fill_done(fill_done),
    .dir_valid(dir_valid), .dir_slot(dir_slot), .dir_vp(dir_vp), .bc_done(bc_done));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  task automatic check(input string req, input string nm, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference model: 0 idle, 1 check, 2 fill, 3 issue
  int m_st, m_addr, m_vp, m_slot, m_idx, m_vict;
  bit m_thr, m_done;
  int m_tag[4];
  bit m_vld[4];
  int qa[$], qv[$];

  always @(posedge clk) begin
    bit do_push;
    int push_a, push_v;
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_vp = 0; m_slot = 0; m_idx = 0; m_vict = 0;
      m_thr = 0; m_done = 0;
      foreach (m_vld[i]) begin m_vld[i] = 0; m_tag[i] = 0; end
      qa.delete(); qv.delete();
    end else begin
      do_push = tf_valid && qa.size() < 4;
      push_a = tf_addr; push_v = tf_vp;
      m_done = (m_st == 3) && !m_thr && m_idx == VPL - 1;
      case (m_st)
        0: if (qa.size() > 0) begin
             m_addr = qa.pop_front(); m_vp = qv.pop_front(); m_thr = 1; m_st = 1;
           end else if (bc_valid) begin
             m_addr = bc_addr; m_thr = 0; m_st = 1;
           end
        1: begin
             int hs;
             hs = -1;
             for (int i = 0; i < 4; i++) if (m_vld[i] && m_tag[i] == m_addr) hs = i;
             m_idx = 0;
             if (hs >= 0) begin m_slot = hs; m_st = 3; end else m_st = 2;
           end
        2: if (fill_done) begin
             m_tag[m_vict] = m_addr; m_vld[m_vict] = 1; m_slot = m_vict;
             m_vict = (m_vict + 1) % 4; m_st = 3;
           end
        default: if (m_thr || m_idx == VPL - 1) m_st = 0; else m_idx++;
      endcase
      if (do_push) begin qa.push_back(push_a); qv.push_back(push_v); end
    end
  end

  int n_dir = 0, n_done = 0;
  int fill_seq[$];

  always begin
    @(posedge clk);
    #6;
    cycles++;
    check("R9", "bc_ready", bc_ready, (m_st == 0) && qa.size() == 0);
    check("R8", "tf_ready", tf_ready, qa.size() < 4);
    check("R5", "fill_req", fill_req, m_st == 2);
    if (m_st == 2) begin
      check("R5", "fill_addr", fill_addr, m_addr);
      check("R7", "fill_slot", fill_slot, m_vict);
    end
    check("R2", "dir_valid", dir_valid, m_st == 3);
    if (m_st == 3) begin
      check("R6", "dir_slot", dir_slot, m_slot);
      if (m_thr) check("R3", "dir_vp", dir_vp, m_vp);
      else check("R2", "dir_vp", dir_vp, LID + m_idx * NL);
    end
    check("R4", "bc_done", bc_done, m_done);
    if (rst_n && dir_valid) n_dir++;
    if (rst_n && bc_done) n_done++;
  end

  // fill responder with varying latency
  int f_cnt = 0, f_num = 0;
  always @(negedge clk) begin
    if (fill_req && !fill_done) begin
      f_cnt++;
      if (f_cnt > 1 + (f_num % 3)) begin
        fill_done <= 1'b1;
        fill_seq.push_back(fill_slot);
        f_cnt = 0; f_num++;
      end
    end else fill_done <= 1'b0;
  end

  always @(posedge clk) if (cycles > 20000) begin
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic send_bc(input int a);
    @(negedge clk);
    bc_valid = 1'b1; bc_addr = AW'(a);
    while (!bc_ready) @(negedge clk);
    @(negedge clk);
    bc_valid = 1'b0;
  endtask

  task automatic send_tf(input int a, input int v);
    @(negedge clk);
    tf_valid = 1'b1; tf_addr = AW'(a); tf_vp = 4'(v);
    while (!tf_ready) @(negedge clk);
    @(negedge clk);
    tf_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!bc_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  bit saw_full = 0;
  always @(negedge clk) if (rst_n && !tf_ready) saw_full = 1;

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset dir_valid", dir_valid, 0);
    check("R1", "reset fill_req", fill_req, 0);
    check("R1", "reset bc_ready", bc_ready, 1);
    check("R1", "reset tf_ready", tf_ready, 1);
    rst_n = 1'b1;
    send_bc('h100);            // R1 first fetch misses, fills slot 0
    wait_idle();
    send_bc('h100);            // R6 hit
    wait_idle();
    check("R4", "done count after two broadcasts", n_done, 2);
    send_tf('h140, 4);
    send_tf('h180, 8);
    send_tf('h100, 12);
    send_tf('h1C0, 0);
    send_tf('h140, 12);
    send_tf('h180, 4);
    @(negedge clk);
    if (!bc_ready) begin        // R9 stray pulse while busy
      bc_valid = 1'b1; bc_addr = AW'('h1C0);
      @(negedge clk);
      bc_valid = 1'b0;
    end
    send_bc('h200);            // R7 wraps to slot 0
    wait_idle();
    send_bc('h140);
    wait_idle();
    check("R8", "queue reached full", saw_full, 1);
    check("R3", "total directives", n_dir, 4 * VPL + 6);
    check("R4", "done count", n_done, 4);
    check("R7", "fill count", fill_seq.size(), 5);
    for (int i = 0; i < fill_seq.size() && i < 5; i++)
      check("R7", "fill slot order", fill_seq[i], i % 4);
    finish_run();
  end
endmodule